// File: doc/BRIEF.md
# Memory-Mapped Interval Timer

This block is a countdown timer that sits on a simple register bus. Software writes a 32-bit interval as two 16-bit halves, then starts the count with a write-1 strobe in the control word. Each clock cycle the counter drops by one. When it runs out, the timer sets a sticky timeout flag. It then either halts or reloads the interval and keeps going, depending on a mode bit.

The timeout flag can raise an interrupt request when that is enabled. Software acknowledges it by writing any value to the status word. A stop strobe halts the count at any time. The bus is single-cycle: a write takes effect at the clock edge where it is presented, and read data appears on the clock edge that samples the read.

At 50 MHz, an interval of 0x0EE6B280 gives five seconds between timeouts.

Top module: `interval_timer`

## Requirements
- R1: After reset the status, control and both interval words read as zero and `irq` is low.
- R2: The interval halves are written at byte offset 8 (low half) and offset 12 (high half) from bits 15:0 of the write data. They read back at the same offsets in bits 15:0, with bits 31:16 reading zero.
- R3: The control word sits at offset 4. Bit 0 is the interrupt enable and bit 1 selects continuous reload; both read back their stored values. Bit 2 (start) and bit 3 (stop) are strobes and always read back as 0.
- R4: The status word sits at offset 0. Bit 0 is the timeout flag and bit 1 reads 1 while the counter runs. Writing 1 to the start bit loads the counter from the interval registers and sets the running state. With continuous reload off and an interval of N, the timeout flag sets on the Nth clock edge after the start write, and on that same edge the running bit clears. An interval of 0 behaves as an interval of 1.
- R5: With continuous reload on, an expiry sets the timeout flag, reloads the interval and leaves the counter running, so later expiries follow every N edges.
- R6: Any write to offset 0 clears the timeout flag. If an expiry happens on the same edge as that write, the flag is set instead.
- R7: Writing 1 to the stop bit clears the running state and no expiry follows. When start and stop are both 1 in one write, stop wins.
- R8: `irq` is high exactly when the timeout flag and the interrupt enable are both 1.
- R9: A read presented at an edge updates `rd_data` at that edge. `rd_data` holds its value while no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (valid with bus_sel) |
| bus_addr | input | 4 | Byte offset; bits 3:2 choose the word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the collision where software's status write lands on the exact edge of an expiry. To get there, the bench counts edges from the start write and places the acknowledging write on edge N. It then checks that the flag survives, and that a second write clears it.

Exact expiry timing is swept over every small interval, both one-shot and continuous. In the continuous runs, the flag is cleared between expiries so each reload edge can be seen on `irq`. The start-plus-stop write is issued while the timer is running, so any wrong priority would show as a running bit or a later interrupt.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned CNT_W  = 2 * HALF_W;
    localparam int unsigned ADDR_W = 4;

    // word index taken from bus_addr[3:2]
    typedef enum logic [1:0] {
        W_STATUS = 2'd0,
        W_CTRL   = 2'd1,
        W_PER_LO = 2'd2,
        W_PER_HI = 2'd3
    } word_e;

    localparam int unsigned B_TMO   = 0;
    localparam int unsigned B_RUN   = 1;
    localparam int unsigned B_IEN   = 0;
    localparam int unsigned B_CONT  = 1;
    localparam int unsigned B_START = 2;
    localparam int unsigned B_STOP  = 3;

    typedef struct packed {
        logic ien;
        logic cont;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
    } cmd_t;

    function automatic word_e word_of(input logic [ADDR_W-1:0] a);
        return word_e'(a[3:2]);
    endfunction

endpackage

// File: rtl/itimer_counter.sv
module itimer_counter
    import itimer_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cmd_t         cmd,
    input  logic         cont,
    input  logic [W-1:0] period,
    output logic         running,
    output logic         expire
);

    logic [W-1:0] count_q;
    logic         at_end;

    // an interval of 0 is treated as 1
    assign at_end = (count_q <= W'(1));
    assign expire = running && !cmd.stop && !cmd.start && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            running <= 1'b0;
        end else if (cmd.stop) begin
            running <= 1'b0;
        end else if (cmd.start) begin
            count_q <= period;
            running <= 1'b1;
        end else if (running) begin
            if (at_end) begin
                if (cont) begin
                    count_q <= period;
                end else begin
                    count_q <= '0;
                    running <= 1'b0;
                end
            end else begin
                count_q <= count_q - W'(1);
            end
        end
    end

endmodule

// File: rtl/itimer_regs.sv
module itimer_regs
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              running,
    input  logic              expire,
    output logic [BUS_W-1:0]  rd_data,
    output cmd_t              cmd,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  period,
    output logic              timeout
);

    logic [HALF_W-1:0] per_lo_q, per_hi_q;
    logic              wr_en, rd_en;
    word_e             word;
    logic [BUS_W-1:0]  rd_mux;

    assign word  = word_of(bus_addr);
    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    assign cmd.start = wr_en && (word == W_CTRL) && wr_data[B_START];
    assign cmd.stop  = wr_en && (word == W_CTRL) && wr_data[B_STOP];
    assign period    = {per_hi_q, per_lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            per_lo_q <= '0;
            per_hi_q <= '0;
            ctrl     <= '0;
            timeout  <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (word)
                    W_CTRL: begin
                        ctrl.ien  <= wr_data[B_IEN];
                        ctrl.cont <= wr_data[B_CONT];
                    end
                    W_PER_LO: per_lo_q <= wr_data[HALF_W-1:0];
                    W_PER_HI: per_hi_q <= wr_data[HALF_W-1:0];
                    default: ;
                endcase
            end
            // a new expiry outranks the acknowledge
            if (expire)
                timeout <= 1'b1;
            else if (wr_en && word == W_STATUS)
                timeout <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (word)
            W_STATUS: begin
                rd_mux[B_TMO] = timeout;
                rd_mux[B_RUN] = running;
            end
            W_CTRL: begin
                rd_mux[B_IEN]  = ctrl.ien;
                rd_mux[B_CONT] = ctrl.cont;
            end
            W_PER_LO: rd_mux[HALF_W-1:0] = per_lo_q;
            W_PER_HI: rd_mux[HALF_W-1:0] = per_hi_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_mux;
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    output logic              irq
);

    cmd_t             cmd;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] period;
    logic             running;
    logic             expire;
    logic             timeout;

    itimer_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_data  (wr_data),
        .running  (running),
        .expire   (expire),
        .rd_data  (rd_data),
        .cmd      (cmd),
        .ctrl     (ctrl),
        .period   (period),
        .timeout  (timeout)
    );

    itimer_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .cont    (ctrl.cont),
        .period  (period),
        .running (running),
        .expire  (expire)
    );

    assign irq = timeout && ctrl.ien;

endmodule

// File: rtl/itimer_chk.sv
module itimer_chk
    import itimer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  wr_data,
    input logic              running,
    input logic              expire,
    input logic              timeout,
    input ctrl_t             ctrl,
    input logic              irq
);

    logic st_wr, ctl_wr;
    assign st_wr  = bus_sel && bus_wr && bus_addr[3:2] == 2'd0;
    assign ctl_wr = bus_sel && bus_wr && bus_addr[3:2] == 2'd1;

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        st_wr && !expire |=> !timeout);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        expire |=> timeout);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        timeout && !st_wr |=> timeout);

    a_r7_stop_wins: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && wr_data[B_STOP] |=> !running);

    a_r4_start_runs: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && wr_data[B_START] && !wr_data[B_STOP] |=> running);

    a_r4_oneshot_halts: assert property (@(posedge clk) disable iff (rst)
        expire && !ctrl.cont |=> !running);

    a_r5_reload_keeps: assert property (@(posedge clk) disable iff (rst)
        expire && ctrl.cont && !ctl_wr |=> running);

    a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl.ien && timeout);

endmodule

bind interval_timer itimer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_data  (wr_data),
    .running  (running),
    .expire   (expire),
    .timeout  (timeout),
    .ctrl     (ctrl),
    .irq      (irq)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    interval_timer u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; wr_data = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = rd_data;
    endtask

    task automatic set_period(input logic [31:0] p);
        wr(4'd8, {16'h0, p[15:0]});
        wr(4'd12, {16'h0, p[31:16]});
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), v);
            chk("R1 reset word", v, 32'h0);
        end
        chk("R1 irq reset", {31'b0, irq}, 32'h0);

        // R2 interval halves
        wr(4'd8, 32'hABCD_1234);
        wr(4'd12, 32'h5555_0EE6);
        rd(4'd8, v);  chk("R2 low half", v, 32'h0000_1234);
        rd(4'd12, v); chk("R2 high half", v, 32'h0000_0EE6);

        // R3 control readback, strobes read 0
        wr(4'd4, 32'h0000_0002);
        rd(4'd4, v); chk("R3 ctrl cont", v, 32'h2);
        wr(4'd4, 32'h0000_0009);   // ien plus stop strobe
        rd(4'd4, v); chk("R3 ctrl ien, strobe reads 0", v, 32'h1);

        // R9 read data holds without a read
        wr(4'd8, 32'h0000_7777);
        @(negedge clk);
        chk("R9 rd_data holds", rd_data, 32'h1);

        // R4 + R8 one-shot sweep
        for (int n = 0; n <= 12; n++) begin
            int ne;
            ne = (n == 0) ? 1 : n;
            set_period(32'(n));
            wr(4'd4, 32'h0000_0005);       // ien, one-shot, start
            for (int k = 1; k <= ne + 2; k++) begin
                @(negedge clk);
                chk("R4 one-shot expiry edge", {31'b0, irq}, {31'b0, k >= ne});
            end
            rd(4'd0, v);
            chk("R4 halted with flag", v, 32'h1);
            wr(4'd0, 32'h0);
            chk("R6 ack clears irq", {31'b0, irq}, 32'h0);
        end

        // R8 irq gated by enable
        set_period(32'd2);
        wr(4'd4, 32'h0000_0004);           // start, ien off
        repeat (3) @(negedge clk);
        chk("R8 irq off when disabled", {31'b0, irq}, 32'h0);
        rd(4'd0, v); chk("R8 flag set while disabled", v, 32'h1);
        wr(4'd4, 32'h0000_0001);
        chk("R8 irq on after enable", {31'b0, irq}, 32'h1);
        wr(4'd0, 32'h0);

        // R5 continuous sweep
        for (int n = 2; n <= 10; n++) begin
            set_period(32'(n));
            wr(4'd4, 32'h0000_0007);       // ien, cont, start
            for (int k = 1; k < n; k++) @(negedge clk);
            chk("R5 before first expiry", {31'b0, irq}, 32'h0);
            @(negedge clk);
            chk("R5 first expiry", {31'b0, irq}, 32'h1);
            wr(4'd0, 32'h0);               // edge n+1
            for (int k = n + 2; k < 2 * n; k++) @(negedge clk);
            if (n > 2) chk("R5 cleared between expiries", {31'b0, irq}, 32'h0);
            @(negedge clk);
            chk("R5 second expiry", {31'b0, irq}, 32'h1);
            rd(4'd0, v);
            chk("R5 still running", v[1], 1'b1);
            wr(4'd4, 32'h0000_0008);       // stop
            wr(4'd0, 32'h0);
        end

        // R7 stop wins over start
        set_period(32'd5);
        wr(4'd4, 32'h0000_0007);
        @(negedge clk);
        wr(4'd4, 32'h0000_000F);           // start and stop
        rd(4'd0, v); chk("R7 start+stop halts", v, 32'h0);
        repeat (10) @(negedge clk);
        chk("R7 no expiry after stop", {31'b0, irq}, 32'h0);

        // R6 acknowledge on the expiry edge: set wins
        set_period(32'd3);
        wr(4'd4, 32'h0000_0005);           // edge 0
        @(negedge clk);                    // edge 1
        @(negedge clk);                    // edge 2
        wr(4'd0, 32'h0);                   // edge 3 = expiry
        chk("R6 set wins over ack", {31'b0, irq}, 32'h1);
        wr(4'd0, 32'h0);
        chk("R6 later ack clears", {31'b0, irq}, 32'h0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule